// File: doc/BRIEF.md
# Programmable pulse pattern sequencer

This block plays a short stored program onto 24 output flag lines. Each program word carries four things: a flag pattern, an opcode, an argument, and a duration in clock cycles. When a word is loaded, its pattern appears on the outputs and stays there for exactly that many cycles. The opcode then decides which word comes next. The sequencer has no arithmetic. Its only flow control is advance, halt, counted loops (which may nest) and subroutine call and return.

A host fills the 512-word program memory through a plain write port while the sequencer is idle. A falling edge on the trigger input starts the program at word 0. The same edge arriving during a run restarts it from word 0. Three status outputs report the state: one while the program runs, one after it has ended, and one when it ended on a stack fault.

Top module: `pps_sequencer`

## Requirements
- R1: A write with `prog_we` high while the sequencer is not running stores the flag pattern, opcode, argument and duration at `prog_addr`. A later run plays that word.
- R2: The flag pattern of a loaded word appears on `flags_out` in the cycle after the load edge. It is held for exactly as many cycles as the word's duration, and the next word appears with no gap.
- R3: A duration below 5 runs as 5 cycles.
- R4: Opcode 0 (advance) moves to the next address when the duration ends. Opcode codes 6 and 7 behave the same way. The argument is ignored.
- R5: Loading a word with opcode 1 (halt) ends the run in that cycle. `running` falls, `halted` rises, and `flags_out` keeps the previous word's pattern.
- R6: Opcode 2 opens a loop whose body starts at the next address. Its argument is the iteration count, and a count of 0 runs the body once. Opcode 3 closes the loop: it jumps back to the start of the body until the count is used up, then falls through. Loops nest up to 4 deep.
- R7: Opcode 4 (call) branches to the address in the argument's low 9 bits and saves the following address. Opcode 5 (return) resumes at the saved address. Calls nest up to 4 deep.
- R8: Any of these stack faults ends the run with `fault` and `halted` high: a call with 4 return addresses already saved, a return with none saved, a loop open with 4 loops active, or a loop close with none active.
- R9: A falling edge on `trig` starts the program at address 0 whether the sequencer is idle or running. It empties both stacks and clears `halted` and `fault`. If it lands on the last cycle of a word, the restart takes precedence over the branch that word would have made.
- R10: Advancing past address 511 ends the run as a halt without `fault`.
- R11: A write while `running` is high does not change the program memory.
- R12: After reset, `flags_out` is 0 and `running`, `halted` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start and restart request, acts on a falling edge |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 9 | Program memory write address |
| prog_flags | input | 24 | Flag pattern of the word being written |
| prog_op | input | 3 | Opcode of the word being written |
| prog_arg | input | 20 | Argument of the word being written |
| prog_dur | input | 32 | Duration of the word being written, in cycles |
| flags_out | output | 24 | Flag pattern of the current word |
| running | output | 1 | High while the program runs |
| halted | output | 1 | High after a run has ended |
| fault | output | 1 | High after a run ended on a stack fault |

## Verification
Two events can fall in the same cycle: a trigger restart and the end of a word's duration, when the sequencer is about to branch. The bench provokes this by pulling the trigger low during the last sampled cycle of a call word, so the edge is seen on the same clock that would take the call. The outcome is judged at the outputs. The flag pattern of word 0 must stay unbroken for the old remaining cycle plus a full fresh duration. The return stack must come out empty, which shows when a later return with no call pending raises the fault. A second case restarts the sequencer in the middle of a subroutine to show that stale return addresses are discarded.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
    localparam int FLAG_W    = 24;
    localparam int OP_W      = 3;
    localparam int ARG_W     = 20;
    localparam int DUR_W     = 32;
    localparam int ADDR_W    = 9;
    localparam int MEM_WORDS = 2 ** ADDR_W;
    localparam int MIN_DUR   = 5;
    localparam int NEST      = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADV     = 3'd0,
        OP_HALT    = 3'd1,
        OP_LOOP    = 3'd2,
        OP_ENDLOOP = 3'd3,
        OP_CALL    = 3'd4,
        OP_RET     = 3'd5
    } op_t;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        op_t               op;
        logic [ARG_W-1:0]  arg;
        logic [DUR_W-1:0]  dur;
    } word_t;

    typedef struct packed {
        logic [ARG_W-1:0]  remain;
        logic [ADDR_W:0]   body;
    } loop_ent_t;

    function automatic logic [DUR_W-1:0] clamp_dur(input logic [DUR_W-1:0] d);
        return (d < DUR_W'(MIN_DUR)) ? DUR_W'(MIN_DUR) : d;
    endfunction
endpackage

// File: rtl/pps_progmem.sv
`timescale 1ns/1ps
module pps_progmem
    import pps_pkg::*;
#(
    parameter int DEPTH = MEM_WORDS
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);
    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/pps_lifo.sv
`timescale 1ns/1ps
module pps_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic         replace,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     slot [DEPTH];
    logic [CNT_W-1:0] used;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] new_idx;

    assign top_idx = IDX_W'(used - 1'b1);
    assign new_idx = IDX_W'(used);
    assign full    = (used == CNT_W'(DEPTH));
    assign empty   = (used == '0);
    assign top     = empty ? '0 : slot[top_idx];

    always_ff @(posedge clk) begin
        if (rst || clear)  used <= '0;
        else if (push)     used <= used + 1'b1;
        else if (pop)      used <= used - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!clear) begin
            if (push)         slot[new_idx] <= din;
            else if (replace) slot[top_idx] <= din;
        end
    end

    // R8: the controller must never push onto a full stack
    p_push_room_r8: assert property (@(posedge clk) disable iff (rst)
        (push && !clear) |-> !full);
    // R8: pops and top rewrites need an entry present
    p_pop_data_r8: assert property (@(posedge clk) disable iff (rst)
        ((pop || replace) && !clear) |-> !empty);
    p_one_op_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({push, pop, replace}) <= 1);
endmodule

// File: rtl/pps_ctrl.sv
`timescale 1ns/1ps
module pps_ctrl
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  word_t             rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [FLAG_W-1:0] flags_q,
    output logic              running,
    output logic              halted,
    output logic              fault,
    output logic              stk_clear,
    output logic              lp_push,
    output logic              lp_pop,
    output logic              lp_wr,
    output loop_ent_t         lp_din,
    input  loop_ent_t         lp_top,
    input  logic              lp_full,
    input  logic              lp_empty,
    output logic              rs_push,
    output logic              rs_pop,
    output logic [ADDR_W:0]   rs_din,
    input  logic [ADDR_W:0]   rs_top,
    input  logic              rs_full,
    input  logic              rs_empty
);
    logic              trig_q;
    logic              start;
    logic [ADDR_W-1:0] pc;
    op_t               cur_op;
    logic [ARG_W-1:0]  cur_arg;
    logic [DUR_W-1:0]  cnt;
    logic              expire;
    logic              err;
    logic [ADDR_W:0]   nxt;
    logic              load;

    assign start     = trig_q & ~trig;
    assign expire    = running & (cnt == '0) & ~start;
    assign stk_clear = start;

    always_comb begin
        nxt     = {1'b0, pc} + 1'b1;
        err     = 1'b0;
        lp_push = 1'b0;
        lp_pop  = 1'b0;
        lp_wr   = 1'b0;
        lp_din  = '0;
        rs_push = 1'b0;
        rs_pop  = 1'b0;
        rs_din  = {1'b0, pc} + 1'b1;
        if (expire) begin
            case (cur_op)
                OP_LOOP: begin
                    if (lp_full) err = 1'b1;
                    else begin
                        lp_push       = 1'b1;
                        lp_din.remain = (cur_arg == '0) ? ARG_W'(1) : cur_arg;
                        lp_din.body   = {1'b0, pc} + 1'b1;
                    end
                end
                OP_ENDLOOP: begin
                    if (lp_empty) err = 1'b1;
                    else if (lp_top.remain > ARG_W'(1)) begin
                        lp_wr         = 1'b1;
                        lp_din        = lp_top;
                        lp_din.remain = lp_top.remain - 1'b1;
                        nxt           = lp_top.body;
                    end else begin
                        lp_pop = 1'b1;
                    end
                end
                OP_CALL: begin
                    if (rs_full) err = 1'b1;
                    else begin
                        rs_push = 1'b1;
                        nxt     = {1'b0, cur_arg[ADDR_W-1:0]};
                    end
                end
                OP_RET: begin
                    if (rs_empty) err = 1'b1;
                    else begin
                        rs_pop = 1'b1;
                        nxt    = rs_top;
                    end
                end
                default: ;
            endcase
        end
    end

    assign load    = start | (expire & ~err & ~nxt[ADDR_W]);
    assign rd_addr = start ? '0 : nxt[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= 1'b0;
            running <= 1'b0;
            halted  <= 1'b0;
            fault   <= 1'b0;
            flags_q <= '0;
            pc      <= '0;
            cur_op  <= OP_ADV;
            cur_arg <= '0;
            cnt     <= '0;
        end else begin
            trig_q <= trig;
            if (start) begin
                halted <= 1'b0;
                fault  <= 1'b0;
            end
            if (load) begin
                pc      <= rd_addr;
                cur_op  <= rd_data.op;
                cur_arg <= rd_data.arg;
                cnt     <= clamp_dur(rd_data.dur) - 1'b1;
                if (rd_data.op == OP_HALT) begin
                    running <= 1'b0;
                    halted  <= 1'b1;
                end else begin
                    running <= 1'b1;
                    flags_q <= rd_data.flags;
                end
            end else if (expire) begin
                running <= 1'b0;
                halted  <= 1'b1;
                if (err) fault <= 1'b1;
            end else if (running) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    logic [7:0] seg_age;
    always_ff @(posedge clk) begin
        if (rst || load)                seg_age <= '0;
        else if (running && seg_age != 8'hFF) seg_age <= seg_age + 1'b1;
    end

    // R2: pattern holds while the word's count is still running
    p_flags_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (running && cnt != '0 && !start) |=> $stable(flags_q));
    // R3: no word ends before the minimum length has elapsed
    p_seg_min_r3: assert property (@(posedge clk) disable iff (rst)
        (expire) |-> (seg_age >= 8'(MIN_DUR - 1)));
    // R5: a run that ends leaves the pattern untouched
    p_end_keeps_flags_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $stable(flags_q));
    // R8: a fault is only ever reported with the run stopped
    p_fault_stops_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> (!running && halted));
    // R9: a trigger edge always lands on address 0
    p_start_zero_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (pc == '0 && !fault));
endmodule

// File: rtl/pps_sequencer.sv
`timescale 1ns/1ps
module pps_sequencer
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [FLAG_W-1:0] prog_flags,
    input  logic [OP_W-1:0]   prog_op,
    input  logic [ARG_W-1:0]  prog_arg,
    input  logic [DUR_W-1:0]  prog_dur,
    output logic [FLAG_W-1:0] flags_out,
    output logic              running,
    output logic              halted,
    output logic              fault
);
    localparam int LOOP_W = $bits(loop_ent_t);

    word_t             wr_word;
    word_t             rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              mem_we;
    logic              stk_clear;
    logic              lp_push, lp_pop, lp_wr, lp_full, lp_empty;
    loop_ent_t         lp_din, lp_top;
    logic [LOOP_W-1:0] lp_top_raw;
    logic              rs_push, rs_pop, rs_full, rs_empty;
    logic [ADDR_W:0]   rs_din, rs_top;

    assign wr_word = '{flags: prog_flags, op: op_t'(prog_op), arg: prog_arg, dur: prog_dur};
    assign mem_we  = prog_we & ~running;
    assign lp_top  = loop_ent_t'(lp_top_raw);

    pps_progmem #(.DEPTH(MEM_WORDS)) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (prog_addr),
        .wr_data (wr_word),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    pps_lifo #(.W(LOOP_W), .DEPTH(NEST)) u_loops (
        .clk     (clk),
        .rst     (rst),
        .clear   (stk_clear),
        .push    (lp_push),
        .pop     (lp_pop),
        .replace (lp_wr),
        .din     (lp_din),
        .top     (lp_top_raw),
        .full    (lp_full),
        .empty   (lp_empty)
    );

    pps_lifo #(.W(ADDR_W + 1), .DEPTH(NEST)) u_returns (
        .clk     (clk),
        .rst     (rst),
        .clear   (stk_clear),
        .push    (rs_push),
        .pop     (rs_pop),
        .replace (1'b0),
        .din     (rs_din),
        .top     (rs_top),
        .full    (rs_full),
        .empty   (rs_empty)
    );

    pps_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .rd_data   (rd_word),
        .rd_addr   (rd_addr),
        .flags_q   (flags_out),
        .running   (running),
        .halted    (halted),
        .fault     (fault),
        .stk_clear (stk_clear),
        .lp_push   (lp_push),
        .lp_pop    (lp_pop),
        .lp_wr     (lp_wr),
        .lp_din    (lp_din),
        .lp_top    (lp_top),
        .lp_full   (lp_full),
        .lp_empty  (lp_empty),
        .rs_push   (rs_push),
        .rs_pop    (rs_pop),
        .rs_din    (rs_din),
        .rs_top    (rs_top),
        .rs_full   (rs_full),
        .rs_empty  (rs_empty)
    );

    // R11: a running sequencer never sees its program change under it
    p_no_write_run_r11: assert property (@(posedge clk) disable iff (rst)
        (prog_we && running) |-> !mem_we);
endmodule

// File: tb/pps_sequencer_test.sv
`timescale 1ns/1ps
module pps_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b1;
    logic        prog_we = 1'b0;
    logic [8:0]  prog_addr = '0;
    logic [23:0] prog_flags = '0;
    logic [2:0]  prog_op = '0;
    logic [19:0] prog_arg = '0;
    logic [31:0] prog_dur = '0;
    logic [23:0] flags_out;
    logic        running, halted, fault;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pps_sequencer uut (
        .clk(clk), .rst(rst), .trig(trig),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_flags(prog_flags),
        .prog_op(prog_op), .prog_arg(prog_arg), .prog_dur(prog_dur),
        .flags_out(flags_out), .running(running), .halted(halted), .fault(fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write one word; called at a negedge, returns at a negedge
    task automatic put(input int a, input logic [23:0] f, input logic [2:0] op,
                       input logic [19:0] arg, input logic [31:0] dur);
        prog_we = 1'b1; prog_addr = 9'(a); prog_flags = f;
        prog_op = op; prog_arg = arg; prog_dur = dur;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // trigger pulse; returns at the first sample of word 0
    task automatic fire();
        trig = 1'b0;
        @(negedge clk);
        trig = 1'b1;
    endtask

    task automatic seg(input string tag, input logic [23:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            check(tag, {8'h0, flags_out}, {8'h0, f});
            check(tag, {31'h0, running}, 32'h1);
            @(negedge clk);
        end
    endtask

    task automatic ended(input string tag, input logic [23:0] f, input logic flt);
        check(tag, {8'h0, flags_out}, {8'h0, f});
        check(tag, {29'h0, running, halted, fault}, {29'h0, 1'b0, 1'b1, flt});
    endtask

    task automatic t_reset();
        check("R12 reset flags", {8'h0, flags_out}, 32'h0);
        check("R12 reset status", {29'h0, running, halted, fault}, 32'h0);
    endtask

    task automatic t_basic();
        put(0, 24'h000011, 3'd0, 20'h55, 5);
        put(1, 24'h000022, 3'd0, 20'h0, 7);
        put(2, 24'h000033, 3'd0, 20'h0, 2);
        put(3, 24'h000044, 3'd6, 20'h0, 0);
        put(4, 24'hFFFFFF, 3'd1, 20'h0, 9);
        fire();
        seg("R1 R2 word0", 24'h000011, 5);
        seg("R2 R4 word1 len7", 24'h000022, 7);
        seg("R3 clamp 2->5", 24'h000033, 5);
        seg("R3 R4 opcode6 clamp 0->5", 24'h000044, 5);
        ended("R5 halt keeps flags", 24'h000044, 1'b0);
    endtask

    task automatic t_loop();
        put(0, 24'h0000A1, 3'd2, 20'd3, 5);
        put(1, 24'h0000B2, 3'd0, 20'd0, 6);
        put(2, 24'h0000C3, 3'd3, 20'd0, 5);
        put(3, 24'h000000, 3'd1, 20'd0, 5);
        fire();
        seg("R6 loop open", 24'h0000A1, 5);
        for (int k = 0; k < 3; k++) begin
            seg("R6 loop body", 24'h0000B2, 6);
            seg("R6 loop close", 24'h0000C3, 5);
        end
        ended("R6 loop exit", 24'h0000C3, 1'b0);
        put(0, 24'h0000A1, 3'd2, 20'd0, 5);
        put(1, 24'h0000C3, 3'd3, 20'd0, 5);
        put(2, 24'h000000, 3'd1, 20'd0, 5);
        fire();
        seg("R6 count0 open", 24'h0000A1, 5);
        seg("R6 count0 once", 24'h0000C3, 5);
        ended("R6 count0 exit", 24'h0000C3, 1'b0);
    endtask

    task automatic t_nest();
        put(0, 24'h000001, 3'd2, 20'd2, 5);
        put(1, 24'h000002, 3'd2, 20'd2, 5);
        put(2, 24'h000003, 3'd3, 20'd0, 5);
        put(3, 24'h000004, 3'd3, 20'd0, 5);
        put(4, 24'h000000, 3'd1, 20'd0, 5);
        fire();
        seg("R6 nest outer", 24'h000001, 5);
        for (int k = 0; k < 2; k++) begin
            seg("R6 nest inner open", 24'h000002, 5);
            seg("R6 nest inner 1", 24'h000003, 5);
            seg("R6 nest inner 2", 24'h000003, 5);
            seg("R6 nest outer close", 24'h000004, 5);
        end
        ended("R6 nest exit", 24'h000004, 1'b0);
    endtask

    task automatic t_call();
        put(0, 24'h00A000, 3'd4, 20'd4, 5);
        put(1, 24'h00B000, 3'd0, 20'd0, 5);
        put(2, 24'h000000, 3'd1, 20'd0, 5);
        put(4, 24'h00E000, 3'd0, 20'd0, 5);
        put(5, 24'h00F000, 3'd5, 20'd0, 5);
        fire();
        seg("R7 call word", 24'h00A000, 5);
        seg("R7 subroutine", 24'h00E000, 5);
        seg("R7 return word", 24'h00F000, 5);
        seg("R7 after return", 24'h00B000, 5);
        ended("R7 end", 24'h00B000, 1'b0);
    endtask

    task automatic t_faults();
        put(0, 24'h0A0000, 3'd5, 20'd0, 5);
        fire();
        seg("R8 return empty word", 24'h0A0000, 5);
        ended("R8 return empty fault", 24'h0A0000, 1'b1);
        put(0, 24'h0B0000, 3'd4, 20'd0, 5);
        fire();
        check("R8 R9 fault cleared", {31'h0, fault}, 32'h0);
        seg("R8 recursive calls", 24'h0B0000, 25);
        ended("R8 call full fault", 24'h0B0000, 1'b1);
    endtask

    task automatic t_end_mem();
        put(0, 24'h111111, 3'd4, 20'd511, 5);
        put(511, 24'h222222, 3'd0, 20'd0, 5);
        fire();
        seg("R10 call to last", 24'h111111, 5);
        seg("R10 last word", 24'h222222, 5);
        ended("R10 past end", 24'h222222, 1'b0);
    endtask

    task automatic t_write_ignored();
        put(0, 24'h333333, 3'd0, 20'd0, 40);
        put(1, 24'h000000, 3'd1, 20'd0, 5);
        fire();
        seg("R11 long word", 24'h333333, 10);
        prog_we = 1'b1; prog_addr = 9'd1; prog_flags = 24'h444444;
        prog_op = 3'd0; prog_arg = 20'd0; prog_dur = 32'd5;
        check("R11 during write", {8'h0, flags_out}, 32'h333333);
        @(negedge clk);
        prog_we = 1'b0;
        seg("R11 long word rest", 24'h333333, 29);
        ended("R11 halt kept", 24'h333333, 1'b0);
        fire();
        seg("R11 rerun", 24'h333333, 40);
        ended("R11 word1 still halt", 24'h333333, 1'b0);
    endtask

    task automatic t_restart();
        put(0, 24'h00C0DE, 3'd4, 20'd4, 5);
        put(1, 24'h00B0B0, 3'd5, 20'd0, 5);
        put(4, 24'h00E0E0, 3'd5, 20'd0, 5);
        fire();
        seg("R9 first call", 24'h00C0DE, 5);
        seg("R9 in subroutine", 24'h00E0E0, 2);
        fire();
        seg("R9 restart mid", 24'h00C0DE, 5);
        seg("R9 subroutine again", 24'h00E0E0, 5);
        seg("R9 returned", 24'h00B0B0, 5);
        ended("R9 stale address dropped", 24'h00B0B0, 1'b1);
        fire();
        seg("R9 collide early", 24'h00C0DE, 4);
        check("R9 collide last", {8'h0, flags_out}, 32'h00C0DE);
        fire();
        seg("R9 restart wins", 24'h00C0DE, 5);
        seg("R9 collide sub", 24'h00E0E0, 5);
        seg("R9 collide ret", 24'h00B0B0, 5);
        ended("R9 collide stack empty", 24'h00B0B0, 1'b1);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_loop();
        t_nest();
        t_call();
        t_faults();
        t_end_mem();
        t_write_ignored();
        t_restart();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule